// File: doc/BRIEF.md
# Direct-Mapped Word Cache Controller

This block sits between a processor request port and a slower main-memory port and keeps a direct-mapped copy of recently used words. Every line holds exactly one word together with a stored tag, a valid flag and a dirty flag. The low word-address bits pick the line, and the remaining upper address bits form the tag. A lookup that finds the line valid and the tag equal completes without touching memory. Any other lookup holds off the processor, reads the word from memory, installs it, and then finishes the original read or write.

The write policy is fixed when the block is elaborated. In write-through form, each write updates the line and is posted into a small first-in first-out buffer that drains to memory in the background. The processor stalls only when that buffer is full. Before a miss fetches from memory, the buffer is drained so the fetch never returns stale data. In write-back form, writes stay in the cache and mark the line dirty. A dirty line is written back to its own address before it is replaced, and a clean line is simply overwritten. A separate invalidate input drops a line that was changed elsewhere.

Both data ports use valid/ready. A processor request transfers on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high, and the requester must hold its fields steady until that cycle. Each transferred request produces exactly one `cpu_rsp_valid` pulse, which has no back-pressure. A memory request is held with stable fields until `mem_req_ready` is high. Each accepted memory read is answered by one `mem_rsp_valid` pulse, after any number of cycles. Memory writes get no answer.

Top module: `wcache_ctrl`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_req_ready` is 1, and `cpu_rsp_valid` and `mem_req_valid` are 0. The first access to any address is a miss.
- R2: Byte-address bits [1:0] are ignored. The line index is address bits [IDX_W+1:2] (IDX_W = log2 LINES), and the tag is all bits above the index. Two addresses with the same index and different tags evict each other.
- R3: A hit (line valid and stored tag equal) gives `cpu_rsp_valid` in the cycle after the transfer, with read data equal to the last value written to that address.
- R4: A miss drops `cpu_req_ready` and reads the word from memory. It installs the word with its tag and sets the line valid, then completes the access. A read miss returns the memory word.
- R5: Write-through: every write updates the cache line and, through the posted buffer, writes the same word to memory at the same word address.
- R6: Write-through: a read miss causes no memory write of its own, and memory reads are issued only when the posted buffer is empty.
- R7: Write-through: when the posted buffer is full, `cpu_req_ready` stays low until an entry drains to memory.
- R8: Write-back: a write updates only the cache and marks the line dirty. No memory request follows a write hit.
- R9: Write-back: replacing a dirty line first writes its word back to its own address. Replacing a clean line issues no memory write.
- R10: An invalidate pulse clears the valid and dirty flags of the given index, so the next access to it misses. Unwritten dirty data of that line is discarded.
- R11: A memory request keeps valid, address and write flag stable until accepted. Any memory read latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | Access completed (one-cycle pulse) |
| cpu_rsp_rdata | output | DATA_W | Read word (the write word for writes) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | DATA_W | Word to write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Returned word |
| inv_valid | input | 1 | Invalidate request |
| inv_index | input | IDX_W | Line to invalidate |

## Verification
On every cycle, the checker confirms several timing and ordering rules. A hit responds in the next cycle, and a miss drops ready at once. In write-through form, no memory read leaves while posted writes are pending. In write-back form, a write hit never reaches memory. A stalled memory request keeps its fields stable. Whether data values are right can only be shown by the bench's sweeps over every index and several tags. The same holds for dirty-line write-back versus clean overwrite, write-buffer stalls, and invalidation that discards dirty data. These sweeps use a small line count and memories with different latencies.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
  typedef enum logic [2:0] {
    WC_IDLE,
    WC_DRAIN,
    WC_EVICT,
    WC_FETCH,
    WC_WAIT
  } wc_state_e;
endpackage

// File: rtl/wcache_store.sv
module wcache_store #(
  parameter int LINES  = 1024,
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // per-line flag flops; an invalidate in the same cycle overrides a write
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_wr, hit_inv;
    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign hit_inv = inv_en && (inv_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (hit_inv) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (hit_wr) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/wcache_wbuf.sv
module wcache_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              do_pop;

  assign do_pop = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop) rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign empty     = (count_q == '0);
  assign full      = (count_q == CNT_FULL);
endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl
  import wcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 1024,
  parameter int WRITE_BACK = 0,
  parameter int WBUF_DEPTH = 4,
  localparam int IDX_W     = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              inv_valid,
  input  logic [IDX_W-1:0]  inv_index
);
  localparam int  OFF_W   = $clog2(DATA_W / 8);
  localparam int  TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam bit  WB_MODE = (WRITE_BACK != 0);

  wc_state_e state_q;

  // request fields and lookup
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              lookup_hit, accept, hit_wr, fill;

  // latched miss
  logic [IDX_W-1:0]  lat_idx_q;
  logic [TAG_W-1:0]  lat_tag_q;
  logic              lat_we_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic [ADDR_W-1:0] victim_addr_q;
  logic [DATA_W-1:0] victim_data_q;

  // store write port
  logic              st_wr_en, st_wr_dirty;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [TAG_W-1:0]  st_wr_tag;
  logic [DATA_W-1:0] st_wr_data;

  // write buffer
  logic              wb_push, wb_pop, wb_empty, wb_full;
  logic [ADDR_W-1:0] wb_head_addr;
  logic [DATA_W-1:0] wb_head_data;

  assign req_idx    = cpu_req_addr[OFF_W +: IDX_W];
  assign req_tag    = cpu_req_addr[ADDR_W-1 -: TAG_W];
  assign lookup_hit = rd_valid && (rd_tag == req_tag);

  assign cpu_req_ready = (state_q == WC_IDLE) && !wb_full;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign hit_wr        = accept && lookup_hit && cpu_req_we;
  assign fill          = (state_q == WC_WAIT) && mem_rsp_valid;

  always_comb begin
    st_wr_en    = hit_wr || fill;
    st_wr_idx   = fill ? lat_idx_q : req_idx;
    st_wr_tag   = fill ? lat_tag_q : req_tag;
    st_wr_data  = fill ? (lat_we_q ? lat_wdata_q : mem_rsp_rdata) : cpu_req_wdata;
    st_wr_dirty = WB_MODE && (fill ? lat_we_q : 1'b1);
  end

  wcache_store #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_idx),
    .rd_valid(rd_valid),
    .rd_dirty(rd_dirty),
    .rd_tag  (rd_tag),
    .rd_data (rd_data),
    .wr_en   (st_wr_en),
    .wr_idx  (st_wr_idx),
    .wr_tag  (st_wr_tag),
    .wr_data (st_wr_data),
    .wr_dirty(st_wr_dirty),
    .inv_en  (inv_valid),
    .inv_idx (inv_index)
  );

  assign wb_push = !WB_MODE && (hit_wr || (fill && lat_we_q));

  if (!WB_MODE) begin : g_wbuf
    wcache_wbuf #(
      .DEPTH (WBUF_DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (wb_push),
      .push_addr({st_wr_tag, st_wr_idx, OFF_W'(0)}),
      .push_data(st_wr_data),
      .pop      (wb_pop),
      .head_addr(wb_head_addr),
      .head_data(wb_head_data),
      .empty    (wb_empty),
      .full     (wb_full)
    );
  end else begin : g_nowbuf
    assign wb_head_addr = '0;
    assign wb_head_data = '0;
    assign wb_empty     = 1'b1;
    assign wb_full      = 1'b0;
  end

  // memory port: eviction, fetch, or posted-write drain
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = wb_head_addr;
    mem_req_wdata = wb_head_data;
    wb_pop        = 1'b0;
    case (state_q)
      WC_EVICT: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = victim_addr_q;
        mem_req_wdata = victim_data_q;
      end
      WC_FETCH: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = {lat_tag_q, lat_idx_q, OFF_W'(0)};
        mem_req_wdata = lat_wdata_q;
      end
      WC_IDLE, WC_DRAIN: begin
        if (!wb_empty) begin
          mem_req_valid = 1'b1;
          mem_req_we    = 1'b1;
          wb_pop        = mem_req_ready;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= WC_IDLE;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
      lat_idx_q     <= '0;
      lat_tag_q     <= '0;
      lat_we_q      <= 1'b0;
      lat_wdata_q   <= '0;
      victim_addr_q <= '0;
      victim_data_q <= '0;
    end else begin
      cpu_rsp_valid <= 1'b0;
      case (state_q)
        WC_IDLE: begin
          if (accept && lookup_hit) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= cpu_req_we ? cpu_req_wdata : rd_data;
          end else if (accept) begin
            lat_idx_q     <= req_idx;
            lat_tag_q     <= req_tag;
            lat_we_q      <= cpu_req_we;
            lat_wdata_q   <= cpu_req_wdata;
            victim_addr_q <= {rd_tag, req_idx, OFF_W'(0)};
            victim_data_q <= rd_data;
            if (WB_MODE) state_q <= (rd_valid && rd_dirty) ? WC_EVICT : WC_FETCH;
            else         state_q <= wb_empty ? WC_FETCH : WC_DRAIN;
          end
        end
        WC_DRAIN: if (wb_empty)     state_q <= WC_FETCH;
        WC_EVICT: if (mem_req_ready) state_q <= WC_FETCH;
        WC_FETCH: if (mem_req_ready) state_q <= WC_WAIT;
        WC_WAIT: begin
          if (mem_rsp_valid) begin
            cpu_rsp_valid <= 1'b1;
            cpu_rsp_rdata <= lat_we_q ? lat_wdata_q : mem_rsp_rdata;
            state_q       <= WC_IDLE;
          end
        end
        default: state_q <= WC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wcache_ctrl_chk.sv
module wcache_ctrl_chk #(
  parameter int WRITE_BACK = 0,
  parameter int ADDR_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              lookup_hit,
  input logic              wb_empty
);
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && lookup_hit) |=> cpu_rsp_valid); // R3

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && !lookup_hit) |=> (!cpu_req_ready && !cpu_rsp_valid)); // R4

  AST_FETCH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((WRITE_BACK == 0) && mem_req_valid && !mem_req_we) |-> wb_empty); // R6

  AST_WB_HIT_STAYS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((WRITE_BACK != 0) && cpu_req_valid && cpu_req_ready && lookup_hit) |=> !mem_req_valid); // R8

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we))); // R11
endmodule

bind wcache_ctrl wcache_ctrl_chk #(
  .WRITE_BACK(WRITE_BACK),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we),
  .mem_req_addr (mem_req_addr),
  .lookup_hit   (lookup_hit),
  .wb_empty     (wb_empty)
);

// File: tb/wcache_ctrl_test.sv
module wcache_mem_model #(
  parameter int LAT = 3,
  parameter int GAP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_we,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output int          wr_count
);
  logic [31:0] mem_q [256];
  int          gap_cnt, rd_cnt;
  logic        rd_busy;
  logic [7:0]  rd_addr;

  assign req_ready = (gap_cnt == 0) && !rd_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_q[i] <= 32'h5A5A0000 + 32'(i) * 32'h00010003;
      gap_cnt   <= 0;
      rd_cnt    <= 0;
      rd_busy   <= 1'b0;
      rd_addr   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      wr_count  <= 0;
    end else begin
      gap_cnt   <= (gap_cnt == GAP - 1) ? 0 : gap_cnt + 1;
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        if (req_we) begin
          mem_q[req_addr[9:2]] <= req_wdata;
          wr_count <= wr_count + 1;
        end else begin
          rd_busy <= 1'b1;
          rd_cnt  <= LAT;
          rd_addr <= req_addr[9:2];
        end
      end else if (rd_busy) begin
        if (rd_cnt == 0) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_q[rd_addr];
          rd_busy   <= 1'b0;
        end else begin
          rd_cnt <= rd_cnt - 1;
        end
      end
    end
  end
endmodule

module wcache_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rq_v [2], rq_we [2], rdy [2], rsp_v [2];
  logic [31:0] rq_a [2], rq_wd [2], rsp_d [2];
  logic        m_v [2], m_r [2], m_we [2], m_rv [2];
  logic [31:0] m_a [2], m_wd [2], m_rd [2];
  logic        inv_v [2];
  logic [3:0]  inv_i [2];
  int          wrc [2];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] gold [2][256];

  wcache_ctrl #(.LINES(NLINES), .WRITE_BACK(0), .WBUF_DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(rq_v[0]), .cpu_req_ready(rdy[0]), .cpu_req_we(rq_we[0]),
    .cpu_req_addr(rq_a[0]), .cpu_req_wdata(rq_wd[0]),
    .cpu_rsp_valid(rsp_v[0]), .cpu_rsp_rdata(rsp_d[0]),
    .mem_req_valid(m_v[0]), .mem_req_ready(m_r[0]), .mem_req_we(m_we[0]),
    .mem_req_addr(m_a[0]), .mem_req_wdata(m_wd[0]),
    .mem_rsp_valid(m_rv[0]), .mem_rsp_rdata(m_rd[0]),
    .inv_valid(inv_v[0]), .inv_index(inv_i[0]));

  wcache_ctrl #(.LINES(NLINES), .WRITE_BACK(1), .WBUF_DEPTH(2)) uut_wb (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(rq_v[1]), .cpu_req_ready(rdy[1]), .cpu_req_we(rq_we[1]),
    .cpu_req_addr(rq_a[1]), .cpu_req_wdata(rq_wd[1]),
    .cpu_rsp_valid(rsp_v[1]), .cpu_rsp_rdata(rsp_d[1]),
    .mem_req_valid(m_v[1]), .mem_req_ready(m_r[1]), .mem_req_we(m_we[1]),
    .mem_req_addr(m_a[1]), .mem_req_wdata(m_wd[1]),
    .mem_rsp_valid(m_rv[1]), .mem_rsp_rdata(m_rd[1]),
    .inv_valid(inv_v[1]), .inv_index(inv_i[1]));

  wcache_mem_model #(.LAT(3), .GAP(4)) mem0 (
    .clk(clk), .rst_n(rst_n), .req_valid(m_v[0]), .req_ready(m_r[0]), .req_we(m_we[0]),
    .req_addr(m_a[0]), .req_wdata(m_wd[0]), .rsp_valid(m_rv[0]), .rsp_rdata(m_rd[0]),
    .wr_count(wrc[0]));

  wcache_mem_model #(.LAT(5), .GAP(3)) mem1 (
    .clk(clk), .rst_n(rst_n), .req_valid(m_v[1]), .req_ready(m_r[1]), .req_we(m_we[1]),
    .req_addr(m_a[1]), .req_wdata(m_wd[1]), .rsp_valid(m_rv[1]), .rsp_rdata(m_rd[1]),
    .wr_count(wrc[1]));

  function automatic logic [31:0] init_word(int w);
    return 32'h5A5A0000 + 32'(w) * 32'h00010003;
  endfunction

  function automatic logic [31:0] mem_peek(int p, int w);
    return (p == 0) ? mem0.mem_q[w] : mem1.mem_q[w];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input int p, input bit we, input logic [31:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int lat, output int stall);
    @(negedge clk);
    rq_v[p] = 1'b1; rq_we[p] = we; rq_a[p] = addr; rq_wd[p] = wd;
    stall = 0;
    while (!rdy[p]) begin @(negedge clk); stall++; end
    @(negedge clk);
    rq_v[p] = 1'b0;
    lat = 1;
    while (!rsp_v[p]) begin @(negedge clk); lat++; end
    rd = rsp_d[p];
  endtask

  task automatic invalidate(input int p, input int idx);
    @(negedge clk);
    inv_v[p] = 1'b1; inv_i[p] = 4'(idx);
    @(negedge clk);
    inv_v[p] = 1'b0;
  endtask

  task automatic run_port(input int p);
    logic [31:0] rd, nv;
    int lat, st, stall_sum, w;
    // cold reads of tag 0: all misses
    for (int i = 0; i < NLINES; i++) begin
      access(p, 1'b0, 32'(i * 4), 32'h0, rd, lat, st);
      check(lat > 1, "R1 R4 first access misses", 32'(lat), 32'd2);
      check(rd == gold[p][i], "R4 R11 miss returns memory word", rd, gold[p][i]);
    end
    // re-reads hit; byte offset bits vary
    for (int i = 0; i < NLINES; i++) begin
      access(p, 1'b0, 32'(i * 4 + (i % 4)), 32'h0, rd, lat, st);
      check(lat == 1, "R3 hit latency", 32'(lat), 32'd1);
      check(rd == gold[p][i], "R2 R3 hit data", rd, gold[p][i]);
    end
    check(wrc[p] == 0, "R6 R9 reads cause no memory write", 32'(wrc[p]), 32'd0);
    // write hits
    for (int i = 0; i < NLINES; i++) begin
      nv = (32'(i) * 32'h11111111) ^ (32'hC0DE0000 + 32'(p));
      access(p, 1'b1, 32'(i * 4), nv, rd, lat, st);
      check(lat == 1, "R5 R8 write hit completes next cycle", 32'(lat), 32'd1);
      gold[p][i] = nv;
    end
    repeat (80) @(negedge clk);
    if (p == 0) begin
      check(wrc[p] == NLINES, "R5 each write reaches memory", 32'(wrc[p]), 32'(NLINES));
      for (int i = 0; i < NLINES; i++)
        check(mem_peek(p, i) == gold[p][i], "R5 memory word", mem_peek(p, i), gold[p][i]);
    end else begin
      check(wrc[p] == 0, "R8 write-back writes stay in cache", 32'(wrc[p]), 32'd0);
      for (int i = 0; i < NLINES; i++)
        check(mem_peek(p, i) == init_word(i), "R8 memory untouched", mem_peek(p, i), init_word(i));
    end
    for (int i = 0; i < NLINES; i++) begin
      access(p, 1'b0, 32'(i * 4), 32'h0, rd, lat, st);
      check(lat == 1 && rd == gold[p][i], "R3 read after write hit", rd, gold[p][i]);
    end
    // conflict sweep over tags 1,2,3,0: every access misses
    for (int k = 1; k <= 4; k++) begin
      for (int i = 0; i < NLINES; i++) begin
        w = (k % 4) * NLINES + i;
        access(p, 1'b0, 32'(w * 4), 32'h0, rd, lat, st);
        check(lat > 1, "R2 same index other tag misses", 32'(lat), 32'd2);
        check(rd == gold[p][w], "R4 refill data", rd, gold[p][w]);
      end
      if (p == 1 && k == 1) begin
        check(wrc[p] == NLINES, "R9 dirty lines written back", 32'(wrc[p]), 32'(NLINES));
        for (int i = 0; i < NLINES; i++)
          check(mem_peek(p, i) == gold[p][i], "R9 written-back word", mem_peek(p, i), gold[p][i]);
      end
    end
    check(wrc[p] == NLINES, "R6 R9 no writes for read misses or clean victims",
          32'(wrc[p]), 32'(NLINES));
    // invalidate a valid clean line
    access(p, 1'b0, 32'(5 * 4), 32'h0, rd, lat, st);
    check(lat == 1, "R3 hit before invalidate", 32'(lat), 32'd1);
    invalidate(p, 5);
    access(p, 1'b0, 32'(5 * 4), 32'h0, rd, lat, st);
    check(lat > 1, "R10 invalidated line misses", 32'(lat), 32'd2);
    check(rd == gold[p][5], "R10 data after invalidate", rd, gold[p][5]);
    // write burst, then invalidate last written line and read it back
    stall_sum = 0;
    for (int i = 8; i < NLINES; i++) begin
      nv = 32'hBEEF0000 + 32'(i) + 32'(p * 256);
      access(p, 1'b1, 32'(i * 4), nv, rd, lat, st);
      stall_sum += st;
      if (p == 0 || i != NLINES - 1) gold[p][i] = nv;
    end
    if (p == 0) check(stall_sum > 0, "R7 full buffer stalls writer", 32'(stall_sum), 32'd1);
    else        check(stall_sum == 0, "R8 write-back writes never wait", 32'(stall_sum), 32'd0);
    invalidate(p, NLINES - 1);
    access(p, 1'b0, 32'((NLINES - 1) * 4), 32'h0, rd, lat, st);
    if (p == 0) check(rd == gold[p][NLINES-1], "R6 drain before fetch, no stale data",
                      rd, gold[p][NLINES-1]);
    else        check(rd == gold[p][NLINES-1], "R10 dirty data discarded",
                      rd, gold[p][NLINES-1]);
    repeat (60) @(negedge clk);
    if (p == 0) begin
      for (int i = 8; i < NLINES; i++)
        check(mem_peek(p, i) == gold[p][i], "R5 burst words in memory", mem_peek(p, i), gold[p][i]);
    end
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      rq_v[p] = 1'b0; rq_we[p] = 1'b0; rq_a[p] = '0; rq_wd[p] = '0;
      inv_v[p] = 1'b0; inv_i[p] = '0;
      for (int w = 0; w < 256; w++) gold[p][w] = init_word(w);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      check(rdy[p] == 1'b1, "R1 ready after reset", 32'(rdy[p]), 32'd1);
      check(rsp_v[p] == 1'b0, "R1 no response after reset", 32'(rsp_v[p]), 32'd0);
      check(m_v[p] == 1'b0, "R1 no memory request after reset", 32'(m_v[p]), 32'd0);
    end
    run_port(0);
    run_port(1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule